// File: doc/BRIEF.md
# SD Block-Gap Transfer Pause Controller

This block decides when a multi-block SD/SDIO data transfer is paused and resumed at a boundary between blocks. The data path reports when a transfer starts and in which direction, when each block finishes and when the whole transfer is complete. The host side supplies three register-level controls: a stop request, a single-cycle continue pulse and a read-wait enable. A stop request never cuts a block short. The pause takes effect only at the next block boundary, whether the transfer is driven by a DMA engine or by software.

While paused, the block holds the card in one of three ways. For a write, it does not start the next block. For a read with read-wait enabled, it drives the read-wait signal on DAT[2]. For a read without read-wait, it stops the SD clock and blocks command issue. Resuming requires the stop request to be low and an explicit continue pulse. The end of the transfer releases every hold.

Top module: `sd_gap_pause_ctrl`

## Requirements
- R1: After reset, pause_o, dat2_drive_o, gap_evt_o and cmd_hold_o are 0, sdclk_en_o is 1, and the controller is idle.
- R2: While a transfer runs, the pause begins (pause_o = 1) on the cycle after a block_done_i pulse that coincides with stop_req_i = 1. A stop request without block_done_i does not pause.
- R3: gap_evt_o is 1 for exactly one cycle, the first cycle in which pause_o is 1.
- R4: The pause holds for as long as stop_req_i stays 1, and a cont_req_i pulse given while stop_req_i is 1 is ignored.
- R5: A cont_req_i pulse while paused and with stop_req_i = 0 ends the pause on the next cycle.
- R6: Clearing stop_req_i without a cont_req_i pulse leaves the transfer paused.
- R7: A paused read with rdwait_en_i = 1 gives dat2_drive_o = 1 and sdclk_en_o = 1.
- R8: A paused read with rdwait_en_i = 0 gives sdclk_en_o = 0, cmd_hold_o = 1 and dat2_drive_o = 0.
- R9: A paused write (direction latched as xfer_read_i = 0 at xfer_start_i) gives pause_o = 1 with dat2_drive_o = 0 and sdclk_en_o = 1.
- R10: dat2_drive_o is never 1 while rdwait_en_i is 0, including when rdwait_en_i drops during a pause.
- R11: xfer_done_i returns the controller to idle from any state on the next cycle and releases all holds. Block-done pulses while idle have no effect.
- R12: susp_ok_o reports 1 exactly when rdwait_en_i is 1.
- R13: cont_req_i outside the paused state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start_i | input | 1 | Pulse: a transfer begins |
| xfer_read_i | input | 1 | Direction sampled at start, 1 = read |
| block_done_i | input | 1 | Pulse: a block finished, a gap is reached |
| xfer_done_i | input | 1 | Pulse: the whole transfer completed |
| stop_req_i | input | 1 | Level: stop at the next block gap |
| cont_req_i | input | 1 | Pulse: continue a paused transfer |
| rdwait_en_i | input | 1 | Card supports read wait on DAT[2] |
| pause_o | output | 1 | Data path must not start the next block |
| dat2_drive_o | output | 1 | Drive read-wait on DAT[2] |
| sdclk_en_o | output | 1 | SD clock enable (0 = clock stopped) |
| cmd_hold_o | output | 1 | Command issue blocked by the clock stop |
| gap_evt_o | output | 1 | One-cycle pulse on entering the pause |
| susp_ok_o | output | 1 | Suspend/resume available |

## Verification
The pause state and gap_evt_o are registered, so a block-gap, continue or done event shows on the outputs one cycle after the edge that samples it. The hold outputs dat2_drive_o, sdclk_en_o and cmd_hold_o, and susp_ok_o, are decoded from the registered state together with the live rdwait_en_i. The bench therefore applies each vector's inputs on the falling edge and holds them through the next rising edge. It compares all outputs 1 ns after that edge, when registered results and the combinational decode of the still-applied inputs are both settled.

// File: rtl/sdgap_pkg.sv
package sdgap_pkg;

    typedef enum logic [1:0] {
        GAP_IDLE    = 2'd0,
        GAP_RUN     = 2'd1,
        GAP_STOPPED = 2'd2
    } gap_state_e;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic pause;
        logic dat2;
        logic clk_en;
        logic cmd_hold;
    } hold_t;

    localparam hold_t HOLD_NONE = '{pause: 1'b0, dat2: 1'b0, clk_en: 1'b1, cmd_hold: 1'b0};

    function automatic hold_t hold_decode(gap_state_e st, xfer_dir_e dir, logic rdw);
        hold_t h;
        h = HOLD_NONE;
        if (st == GAP_STOPPED) begin
            h.pause = 1'b1;
            if (dir == DIR_READ) begin
                if (rdw) begin
                    h.dat2 = 1'b1;
                end else begin
                    h.clk_en   = 1'b0;
                    h.cmd_hold = 1'b1;
                end
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/sdgap_fsm.sv
module sdgap_fsm
    import sdgap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       read_i,
    input  logic       blk_i,
    input  logic       done_i,
    input  logic       stop_i,
    input  logic       cont_i,
    output gap_state_e state_o,
    output xfer_dir_e  dir_o,
    output logic       enter_stop_o
);
    gap_state_e state_q, state_d;
    xfer_dir_e  dir_q;

    always_comb begin
        state_d      = state_q;
        enter_stop_o = 1'b0;
        unique case (state_q)
            GAP_IDLE: begin
                if (start_i) state_d = GAP_RUN;
            end
            GAP_RUN: begin
                if (done_i) begin
                    state_d = GAP_IDLE;
                end else if (blk_i && stop_i) begin
                    state_d      = GAP_STOPPED;
                    enter_stop_o = 1'b1;
                end
            end
            GAP_STOPPED: begin
                if (done_i) begin
                    state_d = GAP_IDLE;
                end else if (cont_i && !stop_i) begin
                    state_d = GAP_RUN;
                end
            end
            default: state_d = GAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GAP_IDLE;
            dir_q   <= DIR_WRITE;
        end else begin
            state_q <= state_d;
            if (state_q == GAP_IDLE && start_i) begin
                dir_q <= read_i ? DIR_READ : DIR_WRITE;
            end
        end
    end

    assign state_o = state_q;
    assign dir_o   = dir_q;
endmodule

// File: rtl/sdgap_event.sv
module sdgap_event (
    input  logic clk,
    input  logic rst,
    input  logic enter_i,
    output logic evt_o
);
    always_ff @(posedge clk) begin
        if (rst) evt_o <= 1'b0;
        else     evt_o <= enter_i;
    end
endmodule

// File: rtl/sdgap_hold.sv
module sdgap_hold
    import sdgap_pkg::*;
(
    input  gap_state_e state_i,
    input  xfer_dir_e  dir_i,
    input  logic       rdw_i,
    output hold_t      hold_o
);
    always_comb hold_o = hold_decode(state_i, dir_i, rdw_i);
endmodule

// File: rtl/sd_gap_pause_ctrl.sv
module sd_gap_pause_ctrl
    import sdgap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xfer_start_i,
    input  logic xfer_read_i,
    input  logic block_done_i,
    input  logic xfer_done_i,
    input  logic stop_req_i,
    input  logic cont_req_i,
    input  logic rdwait_en_i,
    output logic pause_o,
    output logic dat2_drive_o,
    output logic sdclk_en_o,
    output logic cmd_hold_o,
    output logic gap_evt_o,
    output logic susp_ok_o
);
    gap_state_e state;
    xfer_dir_e  dir;
    logic       enter_stop;
    hold_t      hold;

    sdgap_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (xfer_start_i),
        .read_i       (xfer_read_i),
        .blk_i        (block_done_i),
        .done_i       (xfer_done_i),
        .stop_i       (stop_req_i),
        .cont_i       (cont_req_i),
        .state_o      (state),
        .dir_o        (dir),
        .enter_stop_o (enter_stop)
    );

    sdgap_event u_evt (
        .clk     (clk),
        .rst     (rst),
        .enter_i (enter_stop),
        .evt_o   (gap_evt_o)
    );

    sdgap_hold u_hold (
        .state_i (state),
        .dir_i   (dir),
        .rdw_i   (rdwait_en_i),
        .hold_o  (hold)
    );

    assign pause_o      = hold.pause;
    assign dat2_drive_o = hold.dat2;
    assign sdclk_en_o   = hold.clk_en;
    assign cmd_hold_o   = hold.cmd_hold;
    assign susp_ok_o    = rdwait_en_i;
endmodule

// File: rtl/sdgap_pause_chk.sv
module sdgap_pause_chk (
    input logic clk,
    input logic rst,
    input logic xfer_done_i,
    input logic stop_req_i,
    input logic cont_req_i,
    input logic rdwait_en_i,
    input logic pause_o,
    input logic dat2_drive_o,
    input logic sdclk_en_o,
    input logic gap_evt_o
);
    // R10
    dat2_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        dat2_drive_o |-> rdwait_en_i);

    // R3
    gap_evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        gap_evt_o |=> !gap_evt_o);

    // R3
    gap_evt_paused_chk: assert property (@(posedge clk) disable iff (rst)
        gap_evt_o |-> pause_o);

    // R2
    pause_entry_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pause_o) |-> gap_evt_o);

    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done_i |=> (!pause_o && sdclk_en_o && !dat2_drive_o));

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_o && stop_req_i && !xfer_done_i) |=> pause_o);

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_o && !cont_req_i && !xfer_done_i) |=> pause_o);

    // R8
    clk_stop_paused_chk: assert property (@(posedge clk) disable iff (rst)
        !sdclk_en_o |-> (pause_o && !dat2_drive_o));
endmodule

bind sd_gap_pause_ctrl sdgap_pause_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .xfer_done_i  (xfer_done_i),
    .stop_req_i   (stop_req_i),
    .cont_req_i   (cont_req_i),
    .rdwait_en_i  (rdwait_en_i),
    .pause_o      (pause_o),
    .dat2_drive_o (dat2_drive_o),
    .sdclk_en_o   (sdclk_en_o),
    .gap_evt_o    (gap_evt_o)
);

// File: tb/test_sd_gap_pause_ctrl.sv
`timescale 1ns/1ps
module test_sd_gap_pause_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_start_i = 0, xfer_read_i = 0, block_done_i = 0, xfer_done_i = 0;
    logic stop_req_i = 0, cont_req_i = 0, rdwait_en_i = 0;
    logic pause_o, dat2_drive_o, sdclk_en_o, cmd_hold_o, gap_evt_o, susp_ok_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sd_gap_pause_ctrl i_sd_gap_pause_ctrl (
        .clk(clk), .rst(rst),
        .xfer_start_i(xfer_start_i), .xfer_read_i(xfer_read_i),
        .block_done_i(block_done_i), .xfer_done_i(xfer_done_i),
        .stop_req_i(stop_req_i), .cont_req_i(cont_req_i), .rdwait_en_i(rdwait_en_i),
        .pause_o(pause_o), .dat2_drive_o(dat2_drive_o), .sdclk_en_o(sdclk_en_o),
        .cmd_hold_o(cmd_hold_o), .gap_evt_o(gap_evt_o), .susp_ok_o(susp_ok_o)
    );

    // Inputs {start,read,stop,cont,rdw,blk,done} then expected {pause,dat2,clk_en,evt}
    localparam int NV = 20;
    localparam logic [10:0] VEC [NV] = '{
        11'b1100100_0010, // R11 start read
        11'b0010100_0010, // R2 stop without gap
        11'b0010110_1111, // R2 R3 R7 gap reached
        11'b0011100_1110, // R4 cont ignored while stop high
        11'b0000100_1110, // R6 stop cleared, no cont
        11'b0001100_0010, // R5 resume
        11'b0001100_0010, // R13 cont while running
        11'b0010010_1001, // R8 clock stop
        11'b0010001_0010, // R11 done while paused
        11'b0010010_0010, // R11 gap while idle
        11'b1000100_0010, // R9 start write
        11'b0010110_1011, // R9 write paused
        11'b0010100_1010, // R9 write holds
        11'b0001100_0010, // R5 write resume
        11'b0000001_0010, // R11 done
        11'b1100100_0010, // R7 start read
        11'b0010110_1111, // R7 read-wait pause
        11'b0010000_1000, // R10 enable dropped
        11'b0000000_1000, // R6 no cont
        11'b0000001_0010  // R11 done
    };

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state {pause,dat2,clk_en,cmd_hold,evt}
        chk("R1", {pause_o, dat2_drive_o, sdclk_en_o, cmd_hold_o, gap_evt_o}, 5'b00100);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {xfer_start_i, xfer_read_i, stop_req_i, cont_req_i,
             rdwait_en_i, block_done_i, xfer_done_i} = VEC[i][10:4];
            @(posedge clk);
            #1;
            chk($sformatf("vector %0d", i),
                {pause_o, dat2_drive_o, sdclk_en_o, !sdclk_en_o, gap_evt_o},
                {VEC[i][3:2], VEC[i][1], cmd_hold_o, VEC[i][0]});
            chk("R8 cmd hold", {4'b0, cmd_hold_o}, {4'b0, !VEC[i][1]});
        end

        // R12 suspend support follows read-wait enable
        @(negedge clk);
        {xfer_start_i, xfer_read_i, stop_req_i, cont_req_i, block_done_i, xfer_done_i} = '0;
        rdwait_en_i = 1'b0;
        #1 chk("R12", {4'b0, susp_ok_o}, 5'b00000);
        rdwait_en_i = 1'b1;
        #1 chk("R12", {4'b0, susp_ok_o}, 5'b00001);

        // R1 reset during a clock-stop pause
        @(negedge clk);
        xfer_start_i = 1; xfer_read_i = 1; rdwait_en_i = 0;
        @(negedge clk);
        xfer_start_i = 0; stop_req_i = 1; block_done_i = 1;
        @(negedge clk);
        block_done_i = 0;
        #1 chk("R8", {pause_o, dat2_drive_o, sdclk_en_o, cmd_hold_o, 1'b0}, 5'b10010);
        rst = 1'b1;
        @(posedge clk);
        #1 chk("R1", {pause_o, dat2_drive_o, sdclk_en_o, cmd_hold_o, gap_evt_o}, 5'b00100);
        @(negedge clk);
        rst = 1'b0; stop_req_i = 0;

        // R11 gap pulse after reset while idle is ignored
        @(negedge clk);
        stop_req_i = 1; block_done_i = 1;
        @(posedge clk);
        #1 chk("R11", {pause_o, 3'b0, gap_evt_o}, 5'b00000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule